// File: doc/BRIEF.md
# WLAN Frame Airtime Calculator

This block works out how many microseconds a frame spends on the air. It takes the frame's byte length, a transmit-rate index and a channel-bandwidth mode. The rate index selects a bit rate in units of 100 kbit/s. The bandwidth mode sets the SIFS, the preamble length and the OFDM symbol time. The length in bits, with the service and tail bits added, is divided by the bits carried per symbol and rounded up to whole symbols. A restoring divider does this division, one quotient bit per cycle.

The main use is filling a per-rate acknowledgement-timeout table. In ACK mode the block ignores the length input and uses a 10-byte frame. It also replaces the transmit rate with the control rate at which the acknowledgement is sent back. That control rate comes from one of two fixed maps, chosen by a high-ACK-rate enable.

A short-preamble flag gives the second table entry for the rates that allow a short preamble. Each request starts with a one-cycle strobe. The result appears together with a one-cycle done pulse and stays on the output until the next result.

Top module: `airtime_calc`

## Requirements
- R1: In data mode the bit count is 22 plus eight times `len_i`. The dividend is ten times that bit count.
- R2: The symbol count is the dividend divided by (bit rate times symbol time), rounded up. The duration is SIFS + preamble + symbol time × symbols. With `bw_i`=0 (20 MHz) the SIFS is 16 us, the preamble 20 us and the symbol 4 us.
- R3: With `bw_i`=2 (10 MHz) the SIFS is 32 us, the preamble 40 us and the symbol 8 us. With `bw_i`=3 (5 MHz) the SIFS is 64 us, the preamble 80 us and the symbol 16 us.
- R4: With `bw_i`=1 (40 MHz) the SIFS is 8 us, the preamble 14 us and the symbol 4 us.
- R5: Rate indices 0..11 select bit rates of 10, 20, 55, 110, 60, 90, 120, 180, 240, 360, 480 and 540 (×100 kbit/s), in that order. Indices 12..15 behave as index 11.
- R6: With `ack_mode_i`=1 the length is taken as 10 bytes and the index is remapped. If `hi_ack_i`=1, indices 0..11 map to 0,1,1,1,4,4,6,6,8,8,8,8. If `hi_ack_i`=0, indices 0..3 map to 0 and every other index maps to 4.
- R7: If `short_pre_i`=1 and the rate index in effect (after clamping and remapping) is 1, 2 or 3, the duration is reduced by 96 us. The result stops at 0 and does not go below it.
- R8: `done_o` rises on the 20th rising clock edge after the edge that accepts `start_i`, with the default 12-bit length. It is high for exactly one cycle.
- R9: `dur_o` changes only together with `done_o` and holds its value between results.
- R10: A `start_i` that arrives before `done_o` of the current request has no effect on the result. This includes a start in the cycle that raises `done_o`. No extra result follows such a start.
- R11: After reset `done_o` is 0 and `dur_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request strobe; accepted only when idle |
| len_i | input | LEN_W (12) | Frame length in bytes (data mode) |
| rate_idx_i | input | 4 | Transmit-rate index |
| bw_i | input | 2 | Bandwidth mode: 0=20, 1=40, 2=10, 3=5 MHz |
| ack_mode_i | input | 1 | Compute ACK airtime (10 bytes, control rate) |
| hi_ack_i | input | 1 | Use the higher control-rate map in ACK mode |
| short_pre_i | input | 1 | Request the short-preamble variant |
| dur_o | output | DUR_W (16) | Airtime in microseconds |
| done_o | output | 1 | One-cycle result strobe |

## Verification
Two events can land in the same cycle: a new start request and the completion of the current one. The bench provokes this in two ways. It raises a second start in the middle of a division with different operands. It also holds a start in the exact cycle in which the first result's done strobe is raised. A run passes if the value delivered equals the first request's airtime and no second done strobe follows for many cycles.

// File: rtl/airtime_pkg.sv
package airtime_pkg;

    localparam int IDX_W      = 4;
    localparam int RATE_W     = 10;
    localparam int SYM_W      = 5;
    localparam int T_W        = 7;
    localparam int LAST_RATE  = 11;
    localparam int PLCP_BITS  = 22;
    localparam int ACK_BYTES  = 10;
    localparam int SHORT_CUT  = 96;

    localparam int PRE_BASE   = 20;
    localparam int PRE_MIN    = 14;
    localparam int SYM_BASE   = 4;
    localparam int SIFS_FULL  = 16;
    localparam int SIFS_TURBO = 8;
    localparam int SIFS_HALF  = 32;
    localparam int SIFS_QTR   = 64;

    typedef enum logic [1:0] {
        BW_20 = 2'd0,
        BW_40 = 2'd1,
        BW_10 = 2'd2,
        BW_5  = 2'd3
    } bw_e;

    typedef struct packed {
        logic [T_W-1:0]   sifs;
        logic [T_W-1:0]   pre;
        logic [SYM_W-1:0] sym;
    } tcfg_t;

    function automatic logic [RATE_W-1:0] rate_of(input logic [IDX_W-1:0] idx);
        case (idx)
            4'd0:    rate_of = RATE_W'(10);
            4'd1:    rate_of = RATE_W'(20);
            4'd2:    rate_of = RATE_W'(55);
            4'd3:    rate_of = RATE_W'(110);
            4'd4:    rate_of = RATE_W'(60);
            4'd5:    rate_of = RATE_W'(90);
            4'd6:    rate_of = RATE_W'(120);
            4'd7:    rate_of = RATE_W'(180);
            4'd8:    rate_of = RATE_W'(240);
            4'd9:    rate_of = RATE_W'(360);
            4'd10:   rate_of = RATE_W'(480);
            default: rate_of = RATE_W'(540);
        endcase
    endfunction

    function automatic logic [IDX_W-1:0] ack_map(input logic [IDX_W-1:0] idx,
                                                 input logic hi);
        if (!hi) begin
            ack_map = (idx < 4) ? IDX_W'(0) : IDX_W'(4);
        end else begin
            case (idx)
                4'd0:             ack_map = IDX_W'(0);
                4'd1, 4'd2, 4'd3: ack_map = IDX_W'(1);
                4'd4, 4'd5:       ack_map = IDX_W'(4);
                4'd6, 4'd7:       ack_map = IDX_W'(6);
                default:          ack_map = IDX_W'(8);
            endcase
        end
    endfunction

    function automatic logic short_capable(input logic [IDX_W-1:0] idx);
        short_capable = (idx >= 1) && (idx <= 3);
    endfunction

    function automatic tcfg_t mode_cfg(input bw_e bw);
        tcfg_t c;
        case (bw)
            BW_40: begin
                c.sifs = T_W'(SIFS_TURBO);
                c.pre  = T_W'(PRE_MIN);
                c.sym  = SYM_W'(SYM_BASE);
            end
            BW_10: begin
                c.sifs = T_W'(SIFS_HALF);
                c.pre  = T_W'(PRE_BASE * 2);
                c.sym  = SYM_W'(SYM_BASE * 2);
            end
            BW_5: begin
                c.sifs = T_W'(SIFS_QTR);
                c.pre  = T_W'(PRE_BASE * 4);
                c.sym  = SYM_W'(SYM_BASE * 4);
            end
            default: begin
                c.sifs = T_W'(SIFS_FULL);
                c.pre  = T_W'(PRE_BASE);
                c.sym  = SYM_W'(SYM_BASE);
            end
        endcase
        mode_cfg = c;
    endfunction

endpackage

// File: rtl/airtime_rate_sel.sv
module airtime_rate_sel
    import airtime_pkg::*;
#(
    parameter int LEN_W = 12,
    parameter int NUM_W = 19
) (
    input  logic [LEN_W-1:0]  len_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic              ack_mode_i,
    input  logic              hi_ack_i,
    input  logic              short_pre_i,
    output logic [RATE_W-1:0] rate_o,
    output logic [NUM_W-1:0]  num_o,
    output logic              cut_o
);
    localparam int XW = NUM_W + 4;

    logic [IDX_W-1:0] clamped;
    logic [IDX_W-1:0] eff_idx;
    logic [LEN_W-1:0] len_eff;
    logic [XW-1:0]    bits;
    logic [XW-1:0]    dividend;

    always_comb begin
        clamped  = (idx_i > IDX_W'(LAST_RATE)) ? IDX_W'(LAST_RATE) : idx_i;
        eff_idx  = ack_mode_i ? ack_map(clamped, hi_ack_i) : clamped;
        len_eff  = ack_mode_i ? LEN_W'(ACK_BYTES) : len_i;
        bits     = XW'(PLCP_BITS) + (XW'(len_eff) << 3);
        dividend = bits * XW'(10);
        num_o    = dividend[NUM_W-1:0];
        rate_o   = rate_of(eff_idx);
        cut_o    = short_pre_i && short_capable(eff_idx);
    end

    // R6
    always_comb begin
        if (ack_mode_i && !hi_ack_i) begin
            lo_ack_map_chk: assert (eff_idx == IDX_W'(0) || eff_idx == IDX_W'(4));
        end
    end

    // R5
    always_comb begin
        idx_range_chk: assert (eff_idx <= IDX_W'(LAST_RATE));
    end

endmodule

// File: rtl/airtime_bw_cfg.sv
module airtime_bw_cfg
    import airtime_pkg::*;
(
    input  bw_e   bw_i,
    output tcfg_t cfg_o
);
    localparam int N_MODES = 4;

    tcfg_t tab [N_MODES];

    for (genvar g = 0; g < N_MODES; g++) begin : g_mode
        assign tab[g] = mode_cfg(bw_e'(g));
    end

    assign cfg_o = tab[bw_i];

endmodule

// File: rtl/airtime_div.sv
module airtime_div #(
    parameter int NUM_W = 19,
    parameter int DEN_W = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go_i,
    input  logic [NUM_W-1:0] num_i,
    input  logic [DEN_W-1:0] den_i,
    output logic             busy_o,
    output logic             fin_o,
    output logic [NUM_W-1:0] quo_o,
    output logic             rem_nz_o
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    logic [DEN_W-1:0] rem_r;
    logic [DEN_W-1:0] den_r;
    logic [NUM_W-1:0] quo_r;
    logic [CNT_W-1:0] cnt_r;
    logic             busy_r;
    logic             fin_r;

    logic [DEN_W:0]   shifted;
    logic             take;
    logic [DEN_W:0]   diff;
    logic [DEN_W-1:0] rem_nx;

    always_comb begin
        shifted = {rem_r, quo_r[NUM_W-1]};
        take    = shifted >= {1'b0, den_r};
        diff    = shifted - {1'b0, den_r};
        rem_nx  = take ? diff[DEN_W-1:0] : shifted[DEN_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_r  <= '0;
            den_r  <= '0;
            quo_r  <= '0;
            cnt_r  <= '0;
            busy_r <= 1'b0;
            fin_r  <= 1'b0;
        end else begin
            fin_r <= 1'b0;
            if (!busy_r) begin
                if (go_i) begin
                    rem_r  <= '0;
                    den_r  <= den_i;
                    quo_r  <= num_i;
                    cnt_r  <= CNT_W'(NUM_W);
                    busy_r <= 1'b1;
                end
            end else begin
                rem_r <= rem_nx;
                quo_r <= {quo_r[NUM_W-2:0], take};
                cnt_r <= cnt_r - 1'b1;
                if (cnt_r == CNT_W'(1)) begin
                    busy_r <= 1'b0;
                    fin_r  <= 1'b1;
                end
            end
        end
    end

    assign busy_o   = busy_r;
    assign fin_o    = fin_r;
    assign quo_o    = quo_r;
    assign rem_nz_o = (rem_r != '0);

    // R2
    rem_below_den_chk: assert property (@(posedge clk) disable iff (rst)
        busy_r |-> (rem_r < den_r));

    // R5
    nonzero_den_chk: assert property (@(posedge clk) disable iff (rst)
        (go_i && !busy_r) |-> (den_i != '0));

    // R8
    fin_single_chk: assert property (@(posedge clk) disable iff (rst)
        fin_r |=> !fin_r);

endmodule

// File: rtl/airtime_calc.sv
module airtime_calc
    import airtime_pkg::*;
#(
    parameter int LEN_W = 12,
    parameter int DUR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic [3:0]       rate_idx_i,
    input  logic [1:0]       bw_i,
    input  logic             ack_mode_i,
    input  logic             hi_ack_i,
    input  logic             short_pre_i,
    output logic [DUR_W-1:0] dur_o,
    output logic             done_o
);
    localparam int NUM_MAX = (PLCP_BITS + 8 * ((1 << LEN_W) - 1)) * 10;
    localparam int NUM_W   = $clog2(NUM_MAX + 1);
    localparam int DEN_W   = RATE_W + SYM_W;
    localparam int ACC_W   = NUM_W + SYM_W + 2;

    logic [RATE_W-1:0] rate;
    logic [NUM_W-1:0]  num;
    logic              cut;
    tcfg_t             cfg_now;
    logic [DEN_W-1:0]  den;

    logic              busy_r;
    tcfg_t             cfg_r;
    logic              cut_r;
    logic              go;
    logic              div_busy;
    logic              div_fin;
    logic [NUM_W-1:0]  quo;
    logic              rem_nz;

    logic [NUM_W:0]    symbols;
    logic [ACC_W-1:0]  acc;
    logic [ACC_W-1:0]  acc_cut;
    logic [DUR_W-1:0]  dur_r;
    logic              done_r;

    airtime_rate_sel #(.LEN_W(LEN_W), .NUM_W(NUM_W)) u_sel (
        .len_i       (len_i),
        .idx_i       (rate_idx_i),
        .ack_mode_i  (ack_mode_i),
        .hi_ack_i    (hi_ack_i),
        .short_pre_i (short_pre_i),
        .rate_o      (rate),
        .num_o       (num),
        .cut_o       (cut)
    );

    airtime_bw_cfg u_bw (
        .bw_i  (bw_e'(bw_i)),
        .cfg_o (cfg_now)
    );

    assign den = DEN_W'(rate) * DEN_W'(cfg_now.sym);
    assign go  = start_i && !busy_r;

    airtime_div #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .go_i     (go),
        .num_i    (num),
        .den_i    (den),
        .busy_o   (div_busy),
        .fin_o    (div_fin),
        .quo_o    (quo),
        .rem_nz_o (rem_nz)
    );

    always_comb begin
        symbols = {1'b0, quo} + (NUM_W + 1)'(rem_nz);
        acc     = ACC_W'(cfg_r.sifs) + ACC_W'(cfg_r.pre)
                + ACC_W'(cfg_r.sym) * ACC_W'(symbols);
        if (cut_r) begin
            acc_cut = (acc > ACC_W'(SHORT_CUT)) ? acc - ACC_W'(SHORT_CUT) : '0;
        end else begin
            acc_cut = acc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_r <= 1'b0;
            cfg_r  <= '0;
            cut_r  <= 1'b0;
            dur_r  <= '0;
            done_r <= 1'b0;
        end else begin
            done_r <= 1'b0;
            if (go) begin
                busy_r <= 1'b1;
                cfg_r  <= cfg_now;
                cut_r  <= cut;
            end
            if (busy_r && div_fin) begin
                busy_r <= 1'b0;
                dur_r  <= acc_cut[DUR_W-1:0];
                done_r <= 1'b1;
            end
        end
    end

    assign dur_o  = dur_r;
    assign done_o = done_r;

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_r |=> !done_r);

    // R9
    dur_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done_r |-> $stable(dur_r));

    // R10
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_r && start_i) |=> $stable(cfg_r) && $stable(cut_r));

    // R10
    div_tracks_busy_chk: assert property (@(posedge clk) disable iff (rst)
        div_busy |-> busy_r);

    // R2
    floor_chk: assert property (@(posedge clk) disable iff (rst)
        (done_r && !cut_r) |-> (ACC_W'(dur_r) >= ACC_W'(cfg_r.sifs) + ACC_W'(cfg_r.pre)));

endmodule

// File: tb/airtime_calc_test.sv
module airtime_calc_test;
    localparam int CLK_PERIOD = 10;
    localparam int LEN_W      = 12;
    localparam int DUR_W      = 16;
    localparam int LAT        = 21;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start_i = 1'b0;
    logic [LEN_W-1:0] len_i = '0;
    logic [3:0]       rate_idx_i = '0;
    logic [1:0]       bw_i = '0;
    logic             ack_mode_i = 1'b0;
    logic             hi_ack_i = 1'b0;
    logic             short_pre_i = 1'b0;
    logic [DUR_W-1:0] dur_o;
    logic             done_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    airtime_calc #(.LEN_W(LEN_W), .DUR_W(DUR_W)) uut (
        .clk, .rst, .start_i, .len_i, .rate_idx_i, .bw_i,
        .ack_mode_i, .hi_ack_i, .short_pre_i, .dur_o, .done_o
    );

    function automatic int bench_rate(input int idx);
        int tab [12] = '{10, 20, 55, 110, 60, 90, 120, 180, 240, 360, 480, 540};
        return tab[idx];
    endfunction

    function automatic int expect_dur(input int len, input int idx, input int bw,
                                      input bit ack, input bit hi, input bit sp);
        int ackhi [12] = '{0, 1, 1, 1, 4, 4, 6, 6, 8, 8, 8, 8};
        int e, l, sifs, pre, sym, bits, nbits10, per, syms, d;
        e = (idx > 11) ? 11 : idx;
        l = len;
        if (ack) begin
            l = 10;
            e = hi ? ackhi[e] : ((e < 4) ? 0 : 4);
        end
        case (bw)
            1:       begin sifs = 8;  pre = 14; sym = 4;  end
            2:       begin sifs = 32; pre = 40; sym = 8;  end
            3:       begin sifs = 64; pre = 80; sym = 16; end
            default: begin sifs = 16; pre = 20; sym = 4;  end
        endcase
        bits    = 22 + 8 * l;
        nbits10 = bits * 10;
        per     = bench_rate(e) * sym;
        syms    = (nbits10 + per - 1) / per;
        d       = sifs + pre + sym * syms;
        if (sp && e >= 1 && e <= 3) d = (d > 96) ? d - 96 : 0;
        return d;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input int len, input int idx, input int bw,
                         input bit ack, input bit hi, input bit sp);
        len_i       = LEN_W'(len);
        rate_idx_i  = 4'(idx);
        bw_i        = 2'(bw);
        ack_mode_i  = ack;
        hi_ack_i    = hi;
        short_pre_i = sp;
    endtask

    task automatic run(input int len, input int idx, input int bw,
                       input bit ack, input bit hi, input bit sp, input string req);
        int exp;
        int n;
        exp = expect_dur(len, idx, bw, ack, hi, sp);
        @(negedge clk);
        drive(len, idx, bw, ack, hi, sp);
        start_i = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            start_i = 1'b0;
            n++;
        end while (!done_o && n < 100);
        check(n == LAT, "R8 latency", n, LAT);
        check(int'(dur_o) == exp, req, int'(dur_o), exp);
        @(negedge clk);
        check(!done_o, "R8 pulse", int'(done_o), 0);
        check(int'(dur_o) == exp, "R9 hold", int'(dur_o), exp);
    endtask

    initial begin
        int exp_a;
        int n;
        int extra;
        void'($urandom(32'h00C0FFEE));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!done_o, "R11 done", int'(done_o), 0);
        check(dur_o == '0, "R11 dur", int'(dur_o), 0);

        run(0, 4, 0, 0, 0, 0, "R1 empty frame");
        run(100, 7, 0, 0, 0, 0, "R2 20MHz data");
        run(1500, 11, 0, 0, 0, 0, "R2 long frame");
        run(200, 5, 2, 0, 0, 0, "R3 10MHz");
        run(200, 5, 3, 0, 0, 0, "R3 5MHz");
        run(200, 5, 1, 0, 0, 0, "R4 40MHz");
        run(64, 14, 0, 0, 0, 0, "R5 clamp 14");
        run(64, 3, 0, 0, 0, 0, "R5 index 3");
        run(4095, 0, 3, 0, 0, 0, "R1 max length");
        run(999, 11, 0, 1, 0, 0, "R6 lo map ofdm");
        run(0, 2, 0, 1, 0, 0, "R6 lo map cck");
        run(0, 11, 0, 1, 1, 0, "R6 hi map");
        run(0, 6, 2, 1, 1, 0, "R6 hi map 10MHz");
        run(0, 2, 0, 1, 1, 1, "R7 saturate");
        run(0, 2, 0, 1, 0, 1, "R7 index0 no cut");
        run(100, 1, 0, 0, 0, 1, "R7 short cut");
        run(100, 4, 0, 0, 0, 1, "R7 ofdm no cut");

        // R10: second start mid-division and in the done cycle
        exp_a = expect_dur(300, 9, 0, 0, 0, 0);
        @(negedge clk);
        drive(300, 9, 0, 0, 0, 0);
        start_i = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            n++;
            start_i = 1'b0;
            if (n == 4) begin
                drive(7, 0, 3, 0, 0, 1);
                start_i = 1'b1;
            end
            if (n == LAT - 1) start_i = 1'b1;
        end while (!done_o && n < 100);
        start_i = 1'b0;
        check(int'(dur_o) == exp_a, "R10 busy start", int'(dur_o), exp_a);
        extra = 0;
        repeat (40) begin
            @(negedge clk);
            if (done_o) extra++;
        end
        check(extra == 0, "R10 no extra done", extra, 0);

        for (int i = 0; i < 150; i++) begin
            int len, idx, bw;
            bit ack, hi, sp;
            len = int'($urandom_range(0, 4095));
            idx = int'($urandom_range(0, 15));
            bw  = int'($urandom_range(0, 3));
            ack = 1'($urandom_range(0, 1));
            hi  = 1'($urandom_range(0, 1));
            sp  = 1'($urandom_range(0, 1));
            run(len, idx, bw, ack, hi, sp, "R2 R3 R4 R5 R6 R7 random");
        end

        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule